// File: doc/BRIEF.md
# Chained Up-Counter Pair with Trigger Start

Two up-counting timers share one clock and are linked by a single trigger line. The leading timer, once started by software, counts from a preloaded value up to its reload limit and wraps to zero. A 3-bit selector picks what it drives onto the trigger line: its own run flag, a one-cycle pulse each time it wraps, or nothing.

The following timer watches that line through a 3-bit source selector. When its 3-bit mode field selects trigger start, a rising edge on the line switches its counter on and raises a sticky event flag. The counter then keeps running on its own and wraps at its own reload limit. Later edges set the flag again but never restart the counter. Both counters can be preloaded before the leading timer is started. Software clears the flag with a one-cycle pulse.

Top module: `mts_chain`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `m_cnt`, `s_cnt`, `m_run`, `s_run`, `m_trgo` and `s_flag` are all 0.
- R2: A `m_load` pulse sets `m_cnt` to `m_load_val` on the next edge, and the load wins over counting. While `m_run` is 1, `m_cnt` rises by one per clock, and on the edge after reaching `m_arr` it becomes 0. While `m_run` is 0, `m_cnt` holds. A `m_cen_wr` pulse copies `m_cen_val` into `m_run`.
- R3: With `m_mode` = 3'b001, `m_trgo` equals `m_run`.
- R4: With `m_mode` = 3'b010, `m_trgo` is high for exactly the one cycle in which `m_cnt` has just wrapped from `m_arr` to 0 while running. With any other `m_mode` value except 3'b001, `m_trgo` stays low.
- R5: Only `s_tsel` = 3'b000 connects `m_trgo` to the following timer. Any other value leaves it without a trigger: no start and no flag.
- R6: With `s_mode` = 3'b110, a rising edge of the selected trigger seen in cycle k sets `s_run` at the end of cycle k, and `s_cnt` first increments at the end of cycle k+1. With any other `s_mode` value, the trigger is ignored.
- R7: A trigger edge accepted under R6 sets `s_flag`. A one-cycle `s_flag_clr` pulse clears it, and otherwise it holds.
- R8: If `s_flag_clr` and an accepted trigger edge occur in the same cycle, `s_flag` ends set.
- R9: Once `s_run` is 1 it stays 1 until reset, and later trigger edges do not reset, reload or pause `s_cnt`.
- R10: While `s_run` is 1, `s_cnt` rises by one per clock and becomes 0 on the edge after reaching `s_arr`.
- R11: A `s_load` pulse sets `s_cnt` to `s_load_val` on the next edge, so the following timer counts up from its preloaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Synchronous active-high reset |
| m_load | input | 1 | Load pulse for the leading counter |
| m_load_val | input | CNT_W | Value loaded into the leading counter |
| m_arr | input | CNT_W | Reload limit of the leading counter |
| m_mode | input | 3 | Trigger output select (001 run flag, 010 wrap pulse) |
| m_cen_wr | input | 1 | Write strobe for the leading run bit |
| m_cen_val | input | 1 | Value written to the leading run bit |
| s_load | input | 1 | Load pulse for the following counter |
| s_load_val | input | CNT_W | Value loaded into the following counter |
| s_arr | input | CNT_W | Reload limit of the following counter |
| s_tsel | input | 3 | Trigger source select (000 = leading timer) |
| s_mode | input | 3 | Following timer mode (110 = trigger start) |
| s_flag_clr | input | 1 | Clear pulse for the event flag |
| m_cnt | output | CNT_W | Leading counter value |
| m_run | output | 1 | Leading run bit |
| m_trgo | output | 1 | Trigger line |
| s_cnt | output | CNT_W | Following counter value |
| s_run | output | 1 | Following run bit |
| s_flag | output | 1 | Trigger event flag |

## Verification
The bench goes after the one-cycle start latency. A design that counts in the same cycle as the edge, or one cycle late, leaves `s_cnt` off by one against a hand-computed value. It drives a wrap across the leading timer's reload limit, so a pulse emitted one cycle early or late shifts the following count. It also sends a second trigger while the following timer is already running: a design that restarts on that edge shows a small count instead of the accumulated one. Finally it lines up a flag clear with a fresh trigger in the same cycle; a design that gives the clear priority shows a dropped flag.

// File: rtl/mts_pkg.sv
package mts_pkg;

    typedef enum logic [2:0] {
        MM_NONE   = 3'b000,
        MM_ENABLE = 3'b001,
        MM_UPDATE = 3'b010
    } mmode_e;

    typedef enum logic [2:0] {
        SM_OFF     = 3'b000,
        SM_TRIGGER = 3'b110
    } smode_e;

    localparam logic [2:0] TSEL_LEADER = 3'b000;

    typedef struct packed {
        logic run;
        logic wrap;
    } ctl_t;

    function automatic logic is_trig_mode(input logic [2:0] code);
        return code == SM_TRIGGER;
    endfunction

endpackage

// File: rtl/mts_master.sv
module mts_master #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] arr,
    input  logic             cen_wr,
    input  logic             cen_val,
    output logic [CNT_W-1:0] cnt,
    output mts_pkg::ctl_t    ctl
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic at_top;
    assign at_top = (cnt == arr);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            ctl.run  <= 1'b0;
            ctl.wrap <= 1'b0;
        end else begin
            if (cen_wr)
                ctl.run <= cen_val;
            ctl.wrap <= ctl.run && !load && at_top;
            if (load)
                cnt <= load_val;
            else if (ctl.run)
                cnt <= at_top ? '0 : cnt + ONE;
        end
    end
endmodule

// File: rtl/mts_trgo_sel.sv
module mts_trgo_sel (
    input  logic [2:0]    mode,
    input  mts_pkg::ctl_t ctl,
    output logic          trgo
);
    import mts_pkg::*;

    always_comb begin
        case (mmode_e'(mode))
            MM_ENABLE: trgo = ctl.run;
            MM_UPDATE: trgo = ctl.wrap;
            default:   trgo = 1'b0;
        endcase
    end
endmodule

// File: rtl/mts_slave.sv
module mts_slave #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_line,
    input  logic [2:0]       tsel,
    input  logic [2:0]       mode,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] arr,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             run,
    output logic             flag
);
    import mts_pkg::*;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic trig_in, trig_prev, accept;

    assign trig_in = (tsel == TSEL_LEADER) ? trig_line : 1'b0;
    assign accept  = trig_in && !trig_prev && is_trig_mode(mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_prev <= 1'b0;
            run       <= 1'b0;
            flag      <= 1'b0;
            cnt       <= '0;
        end else begin
            trig_prev <= trig_in;
            if (accept)
                run <= 1'b1;
            if (accept)
                flag <= 1'b1;
            else if (flag_clr)
                flag <= 1'b0;
            if (load)
                cnt <= load_val;
            else if (run)
                cnt <= (cnt == arr) ? '0 : cnt + ONE;
        end
    end
endmodule

// File: rtl/mts_chain.sv
module mts_chain #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             m_load,
    input  logic [CNT_W-1:0] m_load_val,
    input  logic [CNT_W-1:0] m_arr,
    input  logic [2:0]       m_mode,
    input  logic             m_cen_wr,
    input  logic             m_cen_val,
    input  logic             s_load,
    input  logic [CNT_W-1:0] s_load_val,
    input  logic [CNT_W-1:0] s_arr,
    input  logic [2:0]       s_tsel,
    input  logic [2:0]       s_mode,
    input  logic             s_flag_clr,
    output logic [CNT_W-1:0] m_cnt,
    output logic             m_run,
    output logic             m_trgo,
    output logic [CNT_W-1:0] s_cnt,
    output logic             s_run,
    output logic             s_flag
);
    mts_pkg::ctl_t m_ctl;

    mts_master #(.CNT_W(CNT_W)) u_master (
        .clk      (clk),
        .rst      (rst),
        .load     (m_load),
        .load_val (m_load_val),
        .arr      (m_arr),
        .cen_wr   (m_cen_wr),
        .cen_val  (m_cen_val),
        .cnt      (m_cnt),
        .ctl      (m_ctl)
    );

    assign m_run = m_ctl.run;

    mts_trgo_sel u_sel (
        .mode (m_mode),
        .ctl  (m_ctl),
        .trgo (m_trgo)
    );

    mts_slave #(.CNT_W(CNT_W)) u_slave (
        .clk       (clk),
        .rst       (rst),
        .trig_line (m_trgo),
        .tsel      (s_tsel),
        .mode      (s_mode),
        .load      (s_load),
        .load_val  (s_load_val),
        .arr       (s_arr),
        .flag_clr  (s_flag_clr),
        .cnt       (s_cnt),
        .run       (s_run),
        .flag      (s_flag)
    );
endmodule

// File: rtl/mts_chain_chk.sv
module mts_chain_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             m_load,
    input logic [CNT_W-1:0] m_arr,
    input logic [2:0]       m_mode,
    input logic             s_load,
    input logic [CNT_W-1:0] s_arr,
    input logic [2:0]       s_mode,
    input logic             s_flag_clr,
    input logic [CNT_W-1:0] m_cnt,
    input logic             m_run,
    input logic             m_trgo,
    input logic [CNT_W-1:0] s_cnt,
    input logic             s_run,
    input logic             s_flag
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    AST_M_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!m_run && !m_load) |=> $stable(m_cnt)); // R2

    AST_M_STEP: assert property (@(posedge clk) disable iff (rst)
        (m_run && !m_load) |=> (m_cnt == (($past(m_cnt) == $past(m_arr)) ? '0 : $past(m_cnt) + ONE))); // R2

    AST_TRGO_RUN: assert property (@(posedge clk) disable iff (rst)
        (m_mode == 3'b001) |-> (m_trgo == m_run)); // R3

    AST_UPD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (m_mode == 3'b010 && m_trgo && m_arr != '0 && $stable(m_mode)) |=> !m_trgo); // R4

    AST_UPD_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (m_mode == 3'b010 && m_trgo) |-> (m_cnt == '0)); // R4

    AST_START_MODE: assert property (@(posedge clk) disable iff (rst)
        $rose(s_run) |-> ($past(s_mode) == 3'b110)); // R6

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (s_flag && !s_flag_clr) |=> s_flag); // R7

    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        s_run |=> s_run); // R9

    AST_S_STEP: assert property (@(posedge clk) disable iff (rst)
        (s_run && !s_load) |=> (s_cnt == (($past(s_cnt) == $past(s_arr)) ? '0 : $past(s_cnt) + ONE))); // R10
endmodule

bind mts_chain mts_chain_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .m_load     (m_load),
    .m_arr      (m_arr),
    .m_mode     (m_mode),
    .s_load     (s_load),
    .s_arr      (s_arr),
    .s_mode     (s_mode),
    .s_flag_clr (s_flag_clr),
    .m_cnt      (m_cnt),
    .m_run      (m_run),
    .m_trgo     (m_trgo),
    .s_cnt      (s_cnt),
    .s_run      (s_run),
    .s_flag     (s_flag)
);

// File: tb/tb_mts_chain.sv
module tb_mts_chain;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst;
    logic         m_load, m_cen_wr, m_cen_val, s_load, s_flag_clr;
    logic [W-1:0] m_load_val, m_arr, s_load_val, s_arr;
    logic [2:0]   m_mode, s_tsel, s_mode;
    logic [W-1:0] m_cnt, s_cnt;
    logic         m_run, m_trgo, s_run, s_flag;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    mts_chain #(.CNT_W(W)) dut (
        .clk(clk), .rst(rst),
        .m_load(m_load), .m_load_val(m_load_val), .m_arr(m_arr), .m_mode(m_mode),
        .m_cen_wr(m_cen_wr), .m_cen_val(m_cen_val),
        .s_load(s_load), .s_load_val(s_load_val), .s_arr(s_arr), .s_tsel(s_tsel),
        .s_mode(s_mode), .s_flag_clr(s_flag_clr),
        .m_cnt(m_cnt), .m_run(m_run), .m_trgo(m_trgo),
        .s_cnt(s_cnt), .s_run(s_run), .s_flag(s_flag)
    );

    typedef struct packed {
        logic [2:0]   mm;
        logic [2:0]   sm;
        logic [2:0]   ts;
        logic [W-1:0] marr;
        logic [W-1:0] minit;
        logic [W-1:0] sarr;
        logic [W-1:0] sinit;
        logic [7:0]   n;
        logic [W-1:0] exp_m;
        logic [W-1:0] exp_s;
        logic         exp_f;
    } vec_t;

    // n = clock edges counted after the edge that sets the leading run bit
    localparam vec_t VEC [9] = '{
        '{3'b001, 3'b110, 3'b000, 16'd100, 16'h10, 16'd200, 16'h20, 8'd5, 16'h15, 16'h24, 1'b1}, // R3 R6 R11
        '{3'b001, 3'b110, 3'b000, 16'hFF,  16'h45, 16'hFF,  16'hE7, 8'd3, 16'h48, 16'hE9, 1'b1}, // R3 R6
        '{3'b010, 3'b110, 3'b000, 16'd3,   16'h0,  16'd50,  16'h0,  8'd6, 16'h2,  16'h1,  1'b1}, // R2 R4
        '{3'b010, 3'b110, 3'b000, 16'd3,   16'h0,  16'd50,  16'h7,  8'd4, 16'h0,  16'h7,  1'b0}, // R4 R6
        '{3'b010, 3'b110, 3'b000, 16'hFF,  16'hFD, 16'hFF,  16'h45, 8'd6, 16'h3,  16'h47, 1'b1}, // R2 R4
        '{3'b000, 3'b110, 3'b000, 16'd100, 16'h0,  16'd50,  16'h3,  8'd6, 16'h6,  16'h3,  1'b0}, // R4
        '{3'b001, 3'b000, 3'b000, 16'd100, 16'h0,  16'd50,  16'h3,  8'd6, 16'h6,  16'h3,  1'b0}, // R6
        '{3'b001, 3'b110, 3'b001, 16'd100, 16'h0,  16'd50,  16'h3,  8'd6, 16'h6,  16'h3,  1'b0}, // R5
        '{3'b001, 3'b110, 3'b000, 16'd100, 16'h0,  16'd10,  16'd9,  8'd4, 16'h4,  16'h1,  1'b1}  // R10
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ticks(input int k);
        for (int i = 0; i < k; i++) tick();
    endtask

    task automatic check(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        m_load = 0; m_cen_wr = 0; m_cen_val = 0; s_load = 0; s_flag_clr = 0;
        m_load_val = '0; s_load_val = '0; m_arr = '0; s_arr = '0;
        m_mode = 3'b000; s_tsel = 3'b000; s_mode = 3'b000;
        ticks(3);
        rst = 1'b0;
    endtask

    task automatic setup_and_start(input vec_t v);
        do_reset();
        m_arr = v.marr; s_arr = v.sarr;
        m_mode = v.mm; s_mode = v.sm; s_tsel = v.ts;
        m_load = 1; m_load_val = v.minit;
        s_load = 1; s_load_val = v.sinit;
        tick();
        m_load = 0; s_load = 0;
        m_cen_wr = 1; m_cen_val = 1;
        tick();
        m_cen_wr = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state, sampled in the cycle after reset falls
        check("R1", "m_cnt", m_cnt, '0);
        check("R1", "s_cnt", s_cnt, '0);
        check("R1", "run/trgo/flag", {m_run, m_trgo, s_run, s_flag}, '0);

        foreach (VEC[i]) begin
            setup_and_start(VEC[i]);
            ticks(VEC[i].n);
            check("R2", $sformatf("vec%0d m_cnt", i), m_cnt, VEC[i].exp_m);
            check("R6", $sformatf("vec%0d s_cnt", i), s_cnt, VEC[i].exp_s);
            check("R7", $sformatf("vec%0d s_flag", i), W'(s_flag), W'(VEC[i].exp_f));
        end

        // R11 and R2: preload while stopped, nothing moves
        do_reset();
        m_load = 1; m_load_val = 16'h1234; s_load = 1; s_load_val = 16'h0abc;
        tick();
        m_load = 0; s_load = 0;
        ticks(3);
        check("R2", "held m_cnt", m_cnt, 16'h1234);
        check("R11", "held s_cnt", s_cnt, 16'h0abc);

        // R7 R8 R9: wrap pulses every 4 cycles, clear alone, then clear with trigger
        setup_and_start('{3'b010, 3'b110, 3'b000, 16'd3, 16'h0, 16'd100, 16'h0, 8'd0, 16'h0, 16'h0, 1'b0});
        ticks(6);
        check("R7", "flag before clear", W'(s_flag), W'(1));
        s_flag_clr = 1;
        tick();
        s_flag_clr = 0;
        check("R7", "flag after clear", W'(s_flag), W'(0));
        check("R9", "s_run stays", W'(s_run), W'(1));
        tick();
        s_flag_clr = 1;
        tick();
        s_flag_clr = 0;
        check("R8", "flag clear+trigger", W'(s_flag), W'(1));
        check("R9", "s_cnt not restarted", s_cnt, 16'd4);
        check("R2", "m_cnt after wraps", m_cnt, 16'd1);

        // R3: stopping the leading timer drops the trigger line in run-flag mode
        setup_and_start(VEC[0]);
        check("R3", "trgo on run", W'(m_trgo), W'(1));
        m_cen_wr = 1; m_cen_val = 0;
        tick();
        m_cen_wr = 0;
        check("R3", "trgo after stop", W'(m_trgo), W'(0));
        check("R9", "s_run after stop", W'(s_run), W'(1));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule